// File: doc/BRIEF.md
# Hashed Region Presence Filter

This block keeps an imprecise record of which memory regions (aligned, power-of-two sized address ranges) hold at least one block in the local cache. Other nodes on the interconnect can then ask whether this node might hold anything in a given region. When the answer is "no", the node can skip its cache tag lookup, and the requester can skip the broadcast. The record is an array of up/down counters. Each counter is selected by a hash of the region number. The cache reports every block fill and every block eviction. A fill moves the selected counter up by one step and an eviction moves it down by one step.

Several regions share each counter, so the filter answers for a superset of the regions that are really cached. A false "may hold" only costs a lookup that was not needed. A false "holds nothing" can never occur as long as the cache reports its fills and evictions faithfully. Each counter can be built as a binary adder or as a linear-feedback shift register that steps forward or backward. A parameter chooses between the two, and both give the same answers.

A query is accepted in one cycle. Its answer appears registered in the next cycle and reflects the counters as they stood before any fill or eviction applied in the query's own cycle.

Top module: `rgn_presence_filter`

## Requirements
- R1: After synchronous reset every counter is empty, `query_resp_valid` is low and every query of any region answers "not held".
- R2: The counter index is the XOR of region-number bits [IDX_W-1:0] and [2*IDX_W-1:IDX_W], where the region number is `addr[ADDR_W-1:REGION_LG]` and IDX_W = log2(ENTRIES).
- R3: A fill (`alloc_valid`) makes every later query whose address hashes to the same counter answer "may hold".
- R4: An eviction (`evict_valid`) undoes one fill on its counter. A counter that has taken N fills keeps answering "may hold" until it has taken N evictions, and answers "not held" after the N-th one.
- R5: Regions that share a counter alias: a query of a region with no cached block answers "may hold" when another region on its counter is held. A held region never answers "not held".
- R6: A fill and an eviction that select the same counter in one cycle leave that counter unchanged.
- R7: A fill and an eviction that select different counters in one cycle are both applied.
- R8: A query's answer appears on `query_may_hold` with `query_resp_valid` high in the cycle after `query_valid`. It uses the counter state from before the updates of its own cycle.
- R9: In the cycle after `query_valid` is low, `query_resp_valid` and `query_may_hold` are both low.
- R10: The shift-register counter style (COUNT_STYLE = CNT_LFSR) gives the same answers as the binary style for every sequence of fills and evictions up to CACHE_BLOCKS outstanding fills on one counter.
- R11: Block-offset bits `addr[REGION_LG-1:0]` and region-number bits at or above position 2*IDX_W do not affect which counter is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | The local cache filled a block this cycle |
| alloc_addr | input | ADDR_W | Address of the filled block |
| evict_valid | input | 1 | The local cache dropped a block this cycle |
| evict_addr | input | ADDR_W | Address of the dropped block |
| query_valid | input | 1 | A region query from the interconnect is present |
| query_addr | input | ADDR_W | Any address inside the queried region |
| query_resp_valid | output | 1 | Registered: a query answer is present |
| query_may_hold | output | 1 | Registered: the queried region may have cached blocks |

## Verification
The bench builds two copies of the filter, one with each counter style. Both use a 16-bit address, 64-byte regions, 8 counters and CACHE_BLOCKS = 20, which gives 5-bit counters. With only eight counters, aliasing regions and offsets that must be ignored are easy to construct by hand. The small block count lets the bench push one counter to its full legal depth of 20 fills and unwind it again. That walk covers most of the shift-register sequence in both directions.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

    // How each presence counter is realised.
    typedef enum logic [0:0] {
        CNT_BINARY = 1'b0,
        CNT_LFSR   = 1'b1
    } cnt_style_e;

    // Per-counter step request for one cycle.
    typedef struct packed {
        logic inc;
        logic dec;
    } cnt_cmd_t;

    // Registered answer to one region query.
    typedef struct packed {
        logic valid;
        logic may_hold;
    } query_resp_t;

    // Maximal-length feedback masks, bit n-1 set for tap n, widths 2..16.
    function automatic logic [31:0] lfsr_taps(input int width);
        logic [31:0] m;
        case (width)
            2:       m = 32'h0000_0003;
            3:       m = 32'h0000_0006;
            4:       m = 32'h0000_000C;
            5:       m = 32'h0000_0014;
            6:       m = 32'h0000_0030;
            7:       m = 32'h0000_0060;
            8:       m = 32'h0000_00B8;
            9:       m = 32'h0000_0110;
            10:      m = 32'h0000_0240;
            11:      m = 32'h0000_0500;
            12:      m = 32'h0000_0829;
            13:      m = 32'h0000_100D;
            14:      m = 32'h0000_2015;
            15:      m = 32'h0000_6000;
            16:      m = 32'h0000_D008;
            default: m = 32'h0000_0000;
        endcase
        return m;
    endfunction

    // Counter width able to hold 0..blocks in both styles.
    function automatic int count_width(input int blocks);
        return $clog2(blocks + 2);
    endfunction

endpackage

// File: rtl/rgn_hash.sv
module rgn_hash #(
    parameter int ADDR_W    = 32,
    parameter int REGION_LG = 10,
    parameter int IDX_W     = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int TAG_W = ADDR_W - REGION_LG;

    logic [TAG_W-1:0] region_num;
    logic [IDX_W-1:0] slice_lo;
    logic [IDX_W-1:0] slice_hi;

    always_comb begin
        region_num = addr[ADDR_W-1:REGION_LG];
        slice_lo   = region_num[IDX_W-1:0];
        slice_hi   = region_num[2*IDX_W-1:IDX_W];
        idx        = slice_lo ^ slice_hi;
    end
endmodule

// File: rtl/rgn_counter.sv
module rgn_counter
    import rgn_pkg::*;
#(
    parameter int         CNT_W = 15,
    parameter cnt_style_e STYLE = CNT_BINARY
) (
    input  logic     clk,
    input  logic     rst,
    input  cnt_cmd_t cmd,
    output logic     nonzero
);
    localparam logic [31:0]      TAPS_FULL = lfsr_taps(CNT_W);
    localparam logic [CNT_W-1:0] TAPS      = TAPS_FULL[CNT_W-1:0];
    localparam logic [CNT_W-1:0] EMPTY     = (STYLE == CNT_LFSR) ? CNT_W'(1) : '0;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_up;
    logic [CNT_W-1:0] cnt_dn;

    generate
        if (STYLE == CNT_LFSR) begin : g_lfsr
            // Forward step shifts left and feeds the tap parity into bit 0;
            // backward step recovers the bit that was shifted out.
            always_comb begin
                cnt_up = {cnt_q[CNT_W-2:0], ^(cnt_q & TAPS)};
                cnt_dn = {(^(cnt_q[CNT_W-1:1] & TAPS[CNT_W-2:0])) ^ cnt_q[0],
                          cnt_q[CNT_W-1:1]};
            end
        end else begin : g_bin
            always_comb begin
                cnt_up = cnt_q + 1'b1;
                cnt_dn = cnt_q - 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= EMPTY;
        end else begin
            case ({cmd.inc, cmd.dec})
                2'b10:   cnt_q <= cnt_up;
                2'b01:   cnt_q <= cnt_dn;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign nonzero = (cnt_q != EMPTY);

    // R3: a lone fill always leaves the counter non-empty.
    a_r3_fill_nonempty: assert property (@(posedge clk) disable iff (rst)
        (cmd.inc && !cmd.dec) |=> nonzero);

    // R6: simultaneous fill and eviction on this counter cancel.
    a_r6_both_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd.inc && cmd.dec) |=> $stable(cnt_q));

    // R4: with no step requested the counter keeps its value.
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmd.inc && !cmd.dec) |=> $stable(cnt_q));

    // R4: an eviction never arrives at an empty counter.
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (cmd.dec && !cmd.inc) |-> nonzero);

    // R1: the first cycle after reset sees an empty counter.
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !nonzero);
endmodule

// File: rtl/rgn_presence_filter.sv
module rgn_presence_filter
    import rgn_pkg::*;
#(
    parameter int         ADDR_W       = 32,
    parameter int         REGION_LG    = 10,
    parameter int         ENTRIES      = 256,
    parameter int         CACHE_BLOCKS = 16384,
    parameter cnt_style_e COUNT_STYLE  = CNT_BINARY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic              query_valid,
    input  logic [ADDR_W-1:0] query_addr,
    output logic              query_resp_valid,
    output logic              query_may_hold
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int CNT_W = count_width(CACHE_BLOCKS);

    logic [IDX_W-1:0]   alloc_idx;
    logic [IDX_W-1:0]   evict_idx;
    logic [IDX_W-1:0]   query_idx;
    cnt_cmd_t           cmd     [ENTRIES];
    logic [ENTRIES-1:0] held;
    query_resp_t        resp_q;

    rgn_hash #(.ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .IDX_W(IDX_W))
        u_hash_alloc (.addr(alloc_addr), .idx(alloc_idx));
    rgn_hash #(.ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .IDX_W(IDX_W))
        u_hash_evict (.addr(evict_addr), .idx(evict_idx));
    rgn_hash #(.ADDR_W(ADDR_W), .REGION_LG(REGION_LG), .IDX_W(IDX_W))
        u_hash_query (.addr(query_addr), .idx(query_idx));

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cnt
            always_comb begin
                cmd[e].inc = alloc_valid && (alloc_idx == IDX_W'(e));
                cmd[e].dec = evict_valid && (evict_idx == IDX_W'(e));
            end

            rgn_counter #(.CNT_W(CNT_W), .STYLE(COUNT_STYLE)) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .cmd     (cmd[e]),
                .nonzero (held[e])
            );
        end
    endgenerate

    // Lookup reads the counters before this cycle's updates take effect.
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid    <= query_valid;
            resp_q.may_hold <= query_valid && held[query_idx];
        end
    end

    assign query_resp_valid = resp_q.valid;
    assign query_may_hold   = resp_q.may_hold;

    // R8: every accepted query is answered in the next cycle.
    a_r8_answer_next: assert property (@(posedge clk) disable iff (rst)
        query_valid |=> query_resp_valid);

    // R9: no query, no answer.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !query_valid |=> (!query_resp_valid && !query_may_hold));

    // R5: a region that was non-empty and untouched answers "may hold".
    a_r5_no_false_miss: assert property (@(posedge clk) disable iff (rst)
        (query_valid && held[query_idx]) |=> query_may_hold);

    // R1: the reset state carries no answer.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !query_resp_valid);
endmodule

// File: tb/tb_rgn_presence_filter.sv
module tb_rgn_presence_filter;
    import rgn_pkg::*;

    localparam int ADDR_W = 16;
    localparam int BLOCKS = 20;

    typedef struct packed {
        logic              av;
        logic [ADDR_W-1:0] aa;
        logic              ev;
        logic [ADDR_W-1:0] ea;
        logic              qv;
        logic [ADDR_W-1:0] qa;
        logic              xv;
        logic              xh;
        logic [7:0]        req;
    } vec_t;

    // Region addresses (64-byte regions, 8 counters):
    // A region 1 -> idx 1, B region 9 -> idx 0, C region 8 -> idx 1,
    // D region 2 -> idx 2, E region 65 -> idx 1, F region 3 -> idx 3.
    localparam logic [ADDR_W-1:0] A  = 16'h0040;
    localparam logic [ADDR_W-1:0] AO = 16'h0055;
    localparam logic [ADDR_W-1:0] B  = 16'h0240;
    localparam logic [ADDR_W-1:0] C  = 16'h0200;
    localparam logic [ADDR_W-1:0] D  = 16'h0080;
    localparam logic [ADDR_W-1:0] E  = 16'h1040;
    localparam logic [ADDR_W-1:0] F  = 16'h00C0;
    localparam logic [ADDR_W-1:0] Z  = 16'h0000;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, Z, 1'b0, Z, 1'b1, A,  1'b1, 1'b0, 8'd1},  // R1 empty
        '{1'b1, A, 1'b0, Z, 1'b1, A,  1'b1, 1'b0, 8'd8},  // R8 pre-update
        '{1'b0, Z, 1'b0, Z, 1'b1, A,  1'b1, 1'b1, 8'd3},  // R3
        '{1'b0, Z, 1'b0, Z, 1'b1, AO, 1'b1, 1'b1, 8'd11}, // R11 offset
        '{1'b0, Z, 1'b0, Z, 1'b1, D,  1'b1, 1'b0, 8'd2},  // R2 other idx
        '{1'b0, Z, 1'b0, Z, 1'b1, C,  1'b1, 1'b1, 8'd5},  // R5 alias
        '{1'b0, Z, 1'b0, Z, 1'b1, E,  1'b1, 1'b1, 8'd11}, // R11 upper bits
        '{1'b1, A, 1'b0, Z, 1'b0, Z,  1'b0, 1'b0, 8'd9},  // R9 no query
        '{1'b0, Z, 1'b1, A, 1'b1, A,  1'b1, 1'b1, 8'd8},  // R8
        '{1'b0, Z, 1'b0, Z, 1'b1, A,  1'b1, 1'b1, 8'd4},  // R4 one left
        '{1'b1, D, 1'b1, A, 1'b1, D,  1'b1, 1'b0, 8'd8},  // R8
        '{1'b0, Z, 1'b0, Z, 1'b1, A,  1'b1, 1'b0, 8'd4},  // R4 empty again
        '{1'b0, Z, 1'b0, Z, 1'b1, D,  1'b1, 1'b1, 8'd7},  // R7 both applied
        '{1'b1, D, 1'b1, D, 1'b1, D,  1'b1, 1'b1, 8'd6},  // R6
        '{1'b0, Z, 1'b0, Z, 1'b1, D,  1'b1, 1'b1, 8'd6},  // R6 unchanged
        '{1'b1, C, 1'b1, D, 1'b1, C,  1'b1, 1'b0, 8'd8},  // R8
        '{1'b0, Z, 1'b0, Z, 1'b1, A,  1'b1, 1'b1, 8'd5},  // R5 alias of C
        '{1'b0, Z, 1'b0, Z, 1'b1, D,  1'b1, 1'b0, 8'd7},  // R7
        '{1'b1, A, 1'b1, C, 1'b1, A,  1'b1, 1'b1, 8'd6},  // R6 same idx
        '{1'b0, Z, 1'b0, Z, 1'b1, A,  1'b1, 1'b1, 8'd6},  // R6
        '{1'b0, Z, 1'b1, A, 1'b1, B,  1'b1, 1'b0, 8'd2},  // R2 idx 0
        '{1'b0, Z, 1'b0, Z, 1'b1, A,  1'b1, 1'b0, 8'd4}   // R4
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              alloc_valid = 1'b0;
    logic [ADDR_W-1:0] alloc_addr  = '0;
    logic              evict_valid = 1'b0;
    logic [ADDR_W-1:0] evict_addr  = '0;
    logic              query_valid = 1'b0;
    logic [ADDR_W-1:0] query_addr  = '0;
    logic              rv_b, mh_b, rv_l, mh_l;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rgn_presence_filter #(
        .ADDR_W(ADDR_W), .REGION_LG(6), .ENTRIES(8),
        .CACHE_BLOCKS(BLOCKS), .COUNT_STYLE(CNT_BINARY)
    ) dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .query_valid(query_valid), .query_addr(query_addr),
        .query_resp_valid(rv_b), .query_may_hold(mh_b)
    );

    rgn_presence_filter #(
        .ADDR_W(ADDR_W), .REGION_LG(6), .ENTRIES(8),
        .CACHE_BLOCKS(BLOCKS), .COUNT_STYLE(CNT_LFSR)
    ) dut_lfsr (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .query_valid(query_valid), .query_addr(query_addr),
        .query_resp_valid(rv_l), .query_may_hold(mh_l)
    );

    task automatic check_one(input string who, input logic av, input logic ah,
                             input logic xv, input logic xh, input int req,
                             input string tag);
        checks++;
        if (av !== xv || ah !== xh) begin
            errors++;
            $display("FAIL R%0d %s %s: valid=%b hold=%b expected valid=%b hold=%b",
                     req, who, tag, av, ah, xv, xh);
        end
    endtask

    // R10: both counter styles must give the same expected answer.
    task automatic check_both(input logic xv, input logic xh, input int req,
                              input string tag);
        check_one("binary", rv_b, mh_b, xv, xh, req, tag);
        check_one("lfsr",   rv_l, mh_l, xv, xh, req, tag);
    endtask

    task automatic drive(input logic av, input logic [ADDR_W-1:0] aa,
                         input logic ev, input logic [ADDR_W-1:0] ea,
                         input logic qv, input logic [ADDR_W-1:0] qa);
        alloc_valid = av; alloc_addr = aa;
        evict_valid = ev; evict_addr = ea;
        query_valid = qv; query_addr = qa;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check_both(1'b0, 1'b0, 1, "reset state R1");

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].av, VECS[i].aa, VECS[i].ev, VECS[i].ea,
                  VECS[i].qv, VECS[i].qa);
            check_both(VECS[i].xv, VECS[i].xh, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R4 / R10: full legal depth on one counter, then unwind it.
        for (int i = 0; i < BLOCKS; i++) drive(1'b1, F, 1'b0, Z, 1'b0, Z);
        drive(1'b0, Z, 1'b0, Z, 1'b1, F);
        check_both(1'b1, 1'b1, 10, "full depth");
        for (int i = 0; i < BLOCKS - 1; i++) begin
            drive(1'b0, Z, 1'b1, F, 1'b0, Z);
            drive(1'b0, Z, 1'b0, Z, 1'b1, F);
            check_both(1'b1, 1'b1, 4, $sformatf("unwind %0d", i));
        end
        drive(1'b0, Z, 1'b1, F, 1'b0, Z);
        drive(1'b0, Z, 1'b0, Z, 1'b1, F);
        check_both(1'b1, 1'b0, 4, "last eviction R4");

        // R1: reset in mid-run clears held regions.
        drive(1'b1, A, 1'b0, Z, 1'b0, Z);
        drive(1'b1, B, 1'b0, Z, 1'b1, A);
        check_both(1'b1, 1'b1, 3, "held before reset");
        rst = 1'b1;
        drive(1'b0, Z, 1'b0, Z, 1'b1, A);
        drive(1'b0, Z, 1'b0, Z, 1'b0, Z);
        rst = 1'b0;
        check_both(1'b0, 1'b0, 1, "after reset R1");
        drive(1'b0, Z, 1'b0, Z, 1'b1, A);
        check_both(1'b1, 1'b0, 1, "A cleared R1");
        drive(1'b0, Z, 1'b0, Z, 1'b1, B);
        check_both(1'b1, 1'b0, 1, "B cleared R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule